// File: doc/BRIEF.md
# Extended-Precision Add/Subtract Dispatcher

This block is the decision stage in front of an extended-precision floating-point adder. Each request carries two operands (sign, 15-bit biased exponent, 64-bit significand and a 2-bit class tag), an add/subtract select, a reverse-operand flag, the 2-bit rounding-control field and the denormal exception mask. One cycle after a request is accepted, the block presents one of four outcomes, together with the operand order, the result sign, the result tag and the exception flags. The four outcomes are a magnitude add, a magnitude subtract (swapped or not), a result it forms itself (zero, infinity, NaN or a copied operand), or an exception with no destination write.

Alignment, rounding and normalisation belong to the downstream datapath. That datapath hands back a plain response (valid, error, sign, tag). The block turns this response into a registered write-back that keeps the destination's old sign when the datapath reports an error.

The request side is valid/ready. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. The decision side is also valid/ready. While `out_valid` is high and `out_ready` is low, every decision output holds steady and `in_ready` is low. When `out_ready` is high, a new request can be accepted in the same cycle as the old decision leaves. The response and write-back pins are plain strobes with no back-pressure.

Top module: `fpd_dispatch`

## Requirements
- R1: Tags are encoded 00 valid, 01 zero, 10 special, 11 empty. A special operand is refined as follows: exponent 0 is a denormal; an all-ones exponent with significand bits 62..0 clear is an infinity; anything else is a NaN. An empty operand yields outcome exception (op code 11) with `out_invalid` set.
- R2: The effective sign of operand B is inverted for a subtract. When `op_rev` is set, both effective signs are inverted as well.
- R3: Finite operands with equal effective signs give op code 00 (magnitude add) with swap 0, tag valid and the common effective sign.
- R4: Finite operands with different effective signs give op code 01 (magnitude subtract). Magnitudes are ordered by exponent, then significand bits 63..32, then bits 31..0. When A is larger, swap is 0 and the sign is A's effective sign. When B is larger, swap is 1 and the sign is B's effective sign.
- R5: Equal magnitudes with opposite effective signs give op code 10 (formed result) with tag zero, exponent 0 and significand 0. The sign is negative only when the rounding field is 01 (round down). The other encodings are 00 nearest, 10 up and 11 toward zero.
- R6: Two zero operands give a formed zero. With equal effective signs the zero takes that sign; otherwise the sign follows the rule of R5.
- R7: When exactly one operand is zero, the result is the other operand with its effective sign. Such a result keeps tag valid, or gets tag special if the operand was a denormal or an infinity. The exception is a denormal with significand bit 63 set: its exponent is incremented and its tag becomes valid.
- R8: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity. Infinities with opposite effective signs give an exception with `out_invalid` set.
- R9: Any denormal operand sets `out_denorm`. With `den_mask` low the outcome is an exception. With it high the denormal is handled as a finite value whose zero exponent counts as 1.
- R10: When an operand is a NaN, the result is that NaN with quiet bit 62 forced to 1, formed with tag special and its own sign. With two NaNs, the one with the larger significand wins, and A wins a tie. `out_invalid` is set only if a NaN had bit 62 clear.
- R11: After reset `out_valid` and `wb_valid` are low. A decision appears the cycle after acceptance, and it is held while `out_ready` is low.
- R12: A response with error set produces, one cycle later, a write-back with the destination's previous sign and the tag write suppressed. Without error, the write-back takes the response's sign and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| a_sign | input | 1 | Operand A sign |
| a_exp | input | EXP_W | Operand A exponent |
| a_sig | input | SIG_W | Operand A significand |
| a_tag | input | 2 | Operand A class tag |
| b_sign | input | 1 | Operand B sign |
| b_exp | input | EXP_W | Operand B exponent |
| b_sig | input | SIG_W | Operand B significand |
| b_tag | input | 2 | Operand B class tag |
| op_sub | input | 1 | 1 selects subtract |
| op_rev | input | 1 | Reverse-operand flag |
| rnd_mode | input | 2 | Rounding-control field |
| den_mask | input | 1 | 1 masks the denormal exception |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Decision consumer ready |
| out_op | output | 2 | 00 add, 01 subtract, 10 formed, 11 exception |
| out_swap | output | 1 | 1: B is the larger operand |
| out_sign | output | 1 | Result sign |
| out_tag | output | 2 | Result tag |
| out_exp | output | EXP_W | Formed result exponent |
| out_sig | output | SIG_W | Formed result significand |
| out_invalid | output | 1 | Invalid-operation flag |
| out_denorm | output | 1 | Denormal-operand flag |
| rsp_valid | input | 1 | Datapath response strobe |
| rsp_err | input | 1 | Datapath error |
| rsp_sign | input | 1 | Datapath result sign |
| rsp_tag | input | 2 | Datapath result tag |
| dst_old_sign | input | 1 | Destination sign before the operation |
| wb_valid | output | 1 | Write-back strobe |
| wb_sign | output | 1 | Sign to write |
| wb_tag_we | output | 1 | Tag write enable |
| wb_tag | output | 2 | Tag to write |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent, a 64-bit significand and 32-bit compare words. This gives the ordering two significand words, so a difference confined to the low word, and one confined to the high word under equal exponents, are both reachable. With the 64-bit significand, the quiet bit at 62 and the explicit integer bit at 63 sit where the NaN and pseudo-denormal cases need them.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_FORM = 2'b10,
    OP_EXC  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    CL_VALID,
    CL_ZERO,
    CL_DENORM,
    CL_INF,
    CL_NAN,
    CL_EMPTY
  } cls_e;

  typedef enum logic [1:0] {
    CMP_EQ,
    CMP_GT,
    CMP_LT
  } cmp_e;

  localparam logic [1:0] RC_DOWN = 2'b01;

endpackage

// File: rtl/fpd_refine.sv
module fpd_refine
  import fpd_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  tag_e             tag,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output cls_e             cls
);
  always_comb begin
    unique case (tag)
      TAG_VALID: cls = CL_VALID;
      TAG_ZERO:  cls = CL_ZERO;
      TAG_EMPTY: cls = CL_EMPTY;
      default: begin
        if (exp_i == '0)
          cls = CL_DENORM;
        else if (&exp_i && (sig_i[SIG_W-2:0] == '0))
          cls = CL_INF;
        else
          cls = CL_NAN;
      end
    endcase
  end
endmodule

// File: rtl/fpd_magcmp.sv
module fpd_magcmp
  import fpd_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int SIG_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  output cmp_e             cmp
);
  localparam int N_WORDS = SIG_W / WORD_W;
  localparam logic [EXP_W-1:0] EXP_ONE = {{(EXP_W-1){1'b0}}, 1'b1};

  logic [EXP_W-1:0] ea, eb;
  logic [N_WORDS-1:0] w_gt, w_lt;

  // a zero exponent on a finite operand counts as the minimum exponent
  assign ea = (a_exp == '0) ? EXP_ONE : a_exp;
  assign eb = (b_exp == '0) ? EXP_ONE : b_exp;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign w_gt[w] = a_sig[w*WORD_W +: WORD_W] > b_sig[w*WORD_W +: WORD_W];
    assign w_lt[w] = a_sig[w*WORD_W +: WORD_W] < b_sig[w*WORD_W +: WORD_W];
  end

  always_comb begin
    cmp = CMP_EQ;
    if (ea > eb)
      cmp = CMP_GT;
    else if (ea < eb)
      cmp = CMP_LT;
    else begin
      for (int w = N_WORDS - 1; w >= 0; w--) begin
        if (cmp == CMP_EQ) begin
          if (w_gt[w])      cmp = CMP_GT;
          else if (w_lt[w]) cmp = CMP_LT;
        end
      end
    end
  end
endmodule

// File: rtl/fpd_decide.sv
module fpd_decide
  import fpd_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  cls_e             a_cls,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  input  cls_e             b_cls,
  input  cmp_e             cmp,
  input  logic             sub,
  input  logic             rev,
  input  logic [1:0]       rc,
  input  logic             dn_mask,
  output op_e              op,
  output logic             swap,
  output logic             sign,
  output tag_e             tag,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             f_inv,
  output logic             f_den
);
  localparam int QBIT = SIG_W - 2;

  logic sa, sb, zsign;
  logic a_nan, b_nan, pick_b;
  logic c_sign, c_pseudo;
  logic [EXP_W-1:0] c_exp;
  logic [SIG_W-1:0] c_sig;
  cls_e c_cls;

  assign sa    = a_sign ^ rev;
  assign sb    = b_sign ^ rev ^ sub;
  assign zsign = (rc == RC_DOWN);

  assign a_nan  = (a_cls == CL_NAN);
  assign b_nan  = (b_cls == CL_NAN);
  assign pick_b = !a_nan || (b_nan && (b_sig > a_sig));

  // operand passed through when its partner is zero
  assign c_sign   = (a_cls == CL_ZERO) ? sb    : sa;
  assign c_exp    = (a_cls == CL_ZERO) ? b_exp : a_exp;
  assign c_sig    = (a_cls == CL_ZERO) ? b_sig : a_sig;
  assign c_cls    = (a_cls == CL_ZERO) ? b_cls : a_cls;
  assign c_pseudo = (c_cls == CL_DENORM) && c_sig[SIG_W-1];

  always_comb begin
    op    = OP_ADD;
    swap  = 1'b0;
    sign  = sa;
    tag   = TAG_VALID;
    exp_o = a_exp;
    sig_o = a_sig;
    f_inv = 1'b0;
    f_den = 1'b0;
    if (a_cls == CL_EMPTY || b_cls == CL_EMPTY) begin
      op    = OP_EXC;
      f_inv = 1'b1;
    end else if (a_nan || b_nan) begin
      op    = OP_FORM;
      tag   = TAG_SPECIAL;
      sign  = pick_b ? b_sign : a_sign;
      exp_o = pick_b ? b_exp  : a_exp;
      sig_o = pick_b ? b_sig  : a_sig;
      sig_o[QBIT] = 1'b1;
      f_inv = (a_nan && !a_sig[QBIT]) || (b_nan && !b_sig[QBIT]);
    end else begin
      f_den = (a_cls == CL_DENORM) || (b_cls == CL_DENORM);
      if (f_den && !dn_mask) begin
        op = OP_EXC;
      end else if (a_cls == CL_ZERO && b_cls == CL_ZERO) begin
        op    = OP_FORM;
        tag   = TAG_ZERO;
        exp_o = '0;
        sig_o = '0;
        sign  = (sa == sb) ? sa : zsign;
      end else if (a_cls == CL_ZERO || b_cls == CL_ZERO) begin
        op    = OP_FORM;
        sign  = c_sign;
        sig_o = c_sig;
        exp_o = c_exp + {{(EXP_W-1){1'b0}}, c_pseudo};
        tag   = (c_cls == CL_VALID || c_pseudo) ? TAG_VALID : TAG_SPECIAL;
      end else if (a_cls == CL_INF) begin
        if (b_cls != CL_INF || sa == sb) begin
          op   = OP_FORM;
          tag  = TAG_SPECIAL;
          sign = sa;
        end else begin
          op    = OP_EXC;
          f_inv = 1'b1;
        end
      end else if (b_cls == CL_INF) begin
        op    = OP_FORM;
        tag   = TAG_SPECIAL;
        sign  = sb;
        exp_o = b_exp;
        sig_o = b_sig;
      end else if (sa == sb) begin
        op = OP_ADD;
      end else begin
        unique case (cmp)
          CMP_GT: op = OP_SUB;
          CMP_LT: begin
            op   = OP_SUB;
            swap = 1'b1;
            sign = sb;
          end
          default: begin
            op    = OP_FORM;
            tag   = TAG_ZERO;
            exp_o = '0;
            sig_o = '0;
            sign  = zsign;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fpd_dispatch.sv
module fpd_dispatch
  import fpd_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int SIG_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [1:0]       a_tag,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  input  logic [1:0]       b_tag,
  input  logic             op_sub,
  input  logic             op_rev,
  input  logic [1:0]       rnd_mode,
  input  logic             den_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_op,
  output logic             out_swap,
  output logic             out_sign,
  output logic [1:0]       out_tag,
  output logic [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_invalid,
  output logic             out_denorm,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic             rsp_sign,
  input  logic [1:0]       rsp_tag,
  input  logic             dst_old_sign,
  output logic             wb_valid,
  output logic             wb_sign,
  output logic             wb_tag_we,
  output logic [1:0]       wb_tag
);
  cls_e a_cls, b_cls;
  cmp_e cmp;
  op_e  d_op;
  tag_e d_tag;
  logic d_swap, d_sign, d_inv, d_den;
  logic [EXP_W-1:0] d_exp;
  logic [SIG_W-1:0] d_sig;
  logic take;

  fpd_refine #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_ref_a (
    .tag(tag_e'(a_tag)), .exp_i(a_exp), .sig_i(a_sig), .cls(a_cls));
  fpd_refine #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_ref_b (
    .tag(tag_e'(b_tag)), .exp_i(b_exp), .sig_i(b_sig), .cls(b_cls));

  fpd_magcmp #(.EXP_W(EXP_W), .SIG_W(SIG_W), .WORD_W(WORD_W)) u_cmp (
    .a_exp(a_exp), .a_sig(a_sig), .b_exp(b_exp), .b_sig(b_sig), .cmp(cmp));

  fpd_decide #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dec (
    .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig), .a_cls(a_cls),
    .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig), .b_cls(b_cls),
    .cmp(cmp), .sub(op_sub), .rev(op_rev), .rc(rnd_mode), .dn_mask(den_mask),
    .op(d_op), .swap(d_swap), .sign(d_sign), .tag(d_tag),
    .exp_o(d_exp), .sig_o(d_sig), .f_inv(d_inv), .f_den(d_den));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_op      <= 2'b00;
      out_swap    <= 1'b0;
      out_sign    <= 1'b0;
      out_tag     <= 2'b00;
      out_exp     <= '0;
      out_sig     <= '0;
      out_invalid <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_op      <= d_op;
        out_swap    <= d_swap;
        out_sign    <= d_sign;
        out_tag     <= d_tag;
        out_exp     <= d_exp;
        out_sig     <= d_sig;
        out_invalid <= d_inv;
        out_denorm  <= d_den;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // write-back: an erroring response keeps the old sign and leaves the tag alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_sign   <= 1'b0;
      wb_tag_we <= 1'b0;
      wb_tag    <= 2'b00;
    end else begin
      wb_valid  <= rsp_valid;
      wb_sign   <= rsp_err ? dst_old_sign : rsp_sign;
      wb_tag_we <= rsp_valid && !rsp_err;
      wb_tag    <= rsp_tag;
    end
  end
endmodule

// File: rtl/fpd_dispatch_chk.sv
module fpd_dispatch_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_op,
  input logic             out_sign,
  input logic [1:0]       out_tag,
  input logic [EXP_W-1:0] out_exp,
  input logic [SIG_W-1:0] out_sig,
  input logic             out_invalid,
  input logic             out_denorm,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             dst_old_sign,
  input logic             wb_valid,
  input logic             wb_sign,
  input logic             wb_tag_we
);
  // R11: a stalled decision stays put
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_sign) && $stable(out_sig)));

  // R11: an accepted request shows up on the next cycle
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R12: an erroring response keeps the previous sign and suppresses the tag write
  a_r12_err_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |=> (wb_valid && !wb_tag_we && (wb_sign == $past(dst_old_sign))));

  // R3 / R4: datapath requests never carry an invalid-operation flag
  a_r3_arith_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == 2'b00 || out_op == 2'b01)) |-> !out_invalid);

  // R9: an exception outcome always has a cause
  a_r9_exc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 2'b11) |-> (out_invalid || out_denorm));

  // R5: a formed zero has cleared fields
  a_r5_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 2'b10 && out_tag == 2'b01) |-> (out_exp == '0 && out_sig == '0));
endmodule

bind fpd_dispatch fpd_dispatch_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_sign(out_sign), .out_tag(out_tag), .out_exp(out_exp), .out_sig(out_sig),
  .out_invalid(out_invalid), .out_denorm(out_denorm),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .dst_old_sign(dst_old_sign),
  .wb_valid(wb_valid), .wb_sign(wb_sign), .wb_tag_we(wb_tag_we));

// File: tb/fpd_dispatch_tb_top.sv
module fpd_dispatch_tb_top;
  localparam int EXP_W = 15;
  localparam int SIG_W = 64;
  localparam logic [1:0] T_VAL = 2'b00, T_ZERO = 2'b01, T_SPEC = 2'b10, T_EMPTY = 2'b11;
  localparam logic [1:0] O_ADD = 2'b00, O_SUB = 2'b01, O_FORM = 2'b10, O_EXC = 2'b11;
  localparam logic [EXP_W-1:0] EMAX = 15'h7FFF;
  localparam logic [SIG_W-1:0] S_INF = 64'h8000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
  logic [SIG_W-1:0] a_sig = '0, b_sig = '0;
  logic [1:0] a_tag = 2'b00, b_tag = 2'b00;
  logic op_sub = 1'b0, op_rev = 1'b0, den_mask = 1'b1;
  logic [1:0] rnd_mode = 2'b00;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] out_op, out_tag;
  logic out_swap, out_sign, out_invalid, out_denorm;
  logic [EXP_W-1:0] out_exp;
  logic [SIG_W-1:0] out_sig;
  logic rsp_valid = 1'b0, rsp_err = 1'b0, rsp_sign = 1'b0, dst_old_sign = 1'b0;
  logic [1:0] rsp_tag = 2'b00;
  logic wb_valid, wb_sign, wb_tag_we;
  logic [1:0] wb_tag;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpd_dispatch #(.EXP_W(EXP_W), .SIG_W(SIG_W)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic as, input logic [EXP_W-1:0] ae, input logic [SIG_W-1:0] asg,
                      input logic [1:0] at, input logic bs, input logic [EXP_W-1:0] be,
                      input logic [SIG_W-1:0] bsg, input logic [1:0] bt,
                      input logic sub, input logic rev, input logic [1:0] rc, input logic dm);
    @(negedge clk);
    a_sign = as; a_exp = ae; a_sig = asg; a_tag = at;
    b_sign = bs; b_exp = be; b_sig = bsg; b_tag = bt;
    op_sub = sub; op_rev = rev; rnd_mode = rc; den_mask = dm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_dec(input string req, input logic [1:0] op, input logic sw,
                            input logic sg, input logic [1:0] tg, input logic inv, input logic den);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " op"}, 64'(out_op), 64'(op));
    if (op == O_ADD || op == O_SUB) check({req, " swap"}, 64'(out_swap), 64'(sw));
    if (op != O_EXC) begin
      check({req, " sign"}, 64'(out_sign), 64'(sg));
      check({req, " tag"}, 64'(out_tag), 64'(tg));
    end
    check({req, " invalid"}, 64'(out_invalid), 64'(inv));
    check({req, " denorm"}, 64'(out_denorm), 64'(den));
  endtask

  task automatic t_reset;
    check("R11 reset out_valid", 64'(out_valid), 64'd0);
    check("R11 reset wb_valid", 64'(wb_valid), 64'd0);
    check("R11 reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_effsign;
    send(0, 15'h4000, S_INF, T_VAL, 0, 15'h4000, S_INF, T_VAL, 0, 0, 2'b00, 1);
    expect_dec("R3 plus plus", O_ADD, 0, 0, T_VAL, 0, 0);
    send(0, 15'h4000, S_INF, T_VAL, 1, 15'h4001, S_INF, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R2 sub negative", O_ADD, 0, 0, T_VAL, 0, 0);
    send(0, 15'h4000, S_INF, T_VAL, 0, 15'h4000, S_INF, T_VAL, 0, 1, 2'b00, 1);
    expect_dec("R2 reverse", O_ADD, 0, 1, T_VAL, 0, 0);
  endtask

  task automatic t_order;
    send(0, 15'h4001, 64'hC000_0000_0000_0000, T_VAL, 0, 15'h4000, 64'hC000_0000_0000_0000, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R4 exp greater", O_SUB, 0, 0, T_VAL, 0, 0);
    send(0, 15'h4000, 64'hC000_0000_0000_0000, T_VAL, 0, 15'h4001, 64'hC000_0000_0000_0000, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R4 exp less", O_SUB, 1, 1, T_VAL, 0, 0);
    send(0, 15'h4000, 64'h8000_0001_0000_0000, T_VAL, 0, 15'h4000, 64'h8000_0002_0000_0000, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R4 high word less", O_SUB, 1, 1, T_VAL, 0, 0);
    send(0, 15'h4000, 64'h8000_0000_0000_0009, T_VAL, 0, 15'h4000, 64'h8000_0000_0000_0003, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R4 low word greater", O_SUB, 0, 0, T_VAL, 0, 0);
    send(1, 15'h4000, 64'h8000_0000_0000_0009, T_VAL, 0, 15'h4000, 64'h8000_0000_0000_0003, T_VAL, 0, 0, 2'b00, 1);
    expect_dec("R4 add mixed signs", O_SUB, 0, 1, T_VAL, 0, 0);
  endtask

  task automatic t_eqzero;
    send(0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R5 equal nearest", O_FORM, 0, 0, T_ZERO, 0, 0);
    check("R5 equal sig", out_sig, 64'd0);
    send(0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 1, 0, 2'b01, 1);
    expect_dec("R5 equal down", O_FORM, 0, 1, T_ZERO, 0, 0);
    send(0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 0, 15'h4000, 64'h9000_0000_0000_0001, T_VAL, 1, 0, 2'b11, 1);
    expect_dec("R5 equal chop", O_FORM, 0, 0, T_ZERO, 0, 0);
  endtask

  task automatic t_zeros;
    send(0, 0, 0, T_ZERO, 0, 0, 0, T_ZERO, 1, 0, 2'b01, 1);
    expect_dec("R6 zeros differ down", O_FORM, 0, 1, T_ZERO, 0, 0);
    send(0, 0, 0, T_ZERO, 0, 0, 0, T_ZERO, 1, 0, 2'b10, 1);
    expect_dec("R6 zeros differ up", O_FORM, 0, 0, T_ZERO, 0, 0);
    send(1, 0, 0, T_ZERO, 1, 0, 0, T_ZERO, 0, 0, 2'b00, 1);
    expect_dec("R6 zeros same neg", O_FORM, 0, 1, T_ZERO, 0, 0);
  endtask

  task automatic t_onezero;
    send(0, 0, 0, T_ZERO, 0, 15'h3FFF, 64'hA000_0000_1234_0000, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R7 zero minus valid", O_FORM, 0, 1, T_VAL, 0, 0);
    check("R7 copy exp", 64'(out_exp), 64'h3FFF);
    check("R7 copy sig", out_sig, 64'hA000_0000_1234_0000);
    send(0, 0, 0, T_ZERO, 0, 0, 64'h8000_0000_0000_0010, T_SPEC, 0, 0, 2'b00, 1);
    expect_dec("R7 pseudo denormal", O_FORM, 0, 0, T_VAL, 0, 1);
    check("R7 pseudo exp", 64'(out_exp), 64'd1);
    send(1, 0, 64'h0000_0000_0000_0100, T_SPEC, 0, 0, 0, T_ZERO, 0, 0, 2'b00, 1);
    expect_dec("R7 true denormal", O_FORM, 0, 1, T_SPEC, 0, 1);
    check("R7 denormal exp", 64'(out_exp), 64'd0);
  endtask

  task automatic t_inf;
    send(0, EMAX, S_INF, T_SPEC, 0, 15'h4000, S_INF, T_VAL, 0, 0, 2'b00, 1);
    expect_dec("R8 inf plus finite", O_FORM, 0, 0, T_SPEC, 0, 0);
    check("R8 inf sig", out_sig, S_INF);
    send(0, EMAX, S_INF, T_SPEC, 0, EMAX, S_INF, T_SPEC, 1, 0, 2'b00, 1);
    expect_dec("R8 inf minus inf", O_EXC, 0, 0, T_VAL, 1, 0);
    send(1, EMAX, S_INF, T_SPEC, 1, EMAX, S_INF, T_SPEC, 0, 0, 2'b00, 1);
    expect_dec("R8 same inf", O_FORM, 0, 1, T_SPEC, 0, 0);
    send(0, 15'h4000, S_INF, T_VAL, 0, EMAX, S_INF, T_SPEC, 1, 0, 2'b00, 1);
    expect_dec("R8 finite minus inf", O_FORM, 0, 1, T_SPEC, 0, 0);
    check("R8 b inf exp", 64'(out_exp), 64'(EMAX));
  endtask

  task automatic t_denorm;
    send(0, 0, 64'h0000_0000_0000_0100, T_SPEC, 0, 15'h0001, S_INF, T_VAL, 0, 0, 2'b00, 0);
    expect_dec("R9 unmasked", O_EXC, 0, 0, T_VAL, 0, 1);
    send(0, 0, 64'h0000_0000_0000_0100, T_SPEC, 0, 15'h0001, S_INF, T_VAL, 1, 0, 2'b00, 1);
    expect_dec("R9 masked", O_SUB, 1, 1, T_VAL, 0, 1);
  endtask

  task automatic t_nan;
    send(1, EMAX, 64'hC000_0000_0000_0001, T_SPEC, 0, 15'h4000, S_INF, T_VAL, 0, 0, 2'b00, 1);
    expect_dec("R10 quiet a", O_FORM, 0, 1, T_SPEC, 0, 0);
    check("R10 quiet sig", out_sig, 64'hC000_0000_0000_0001);
    send(0, 15'h4000, S_INF, T_VAL, 0, EMAX, 64'h8000_0000_0000_0005, T_SPEC, 1, 0, 2'b00, 1);
    expect_dec("R10 signalling b", O_FORM, 0, 0, T_SPEC, 1, 0);
    check("R10 quieted sig", out_sig, 64'hC000_0000_0000_0005);
    send(0, EMAX, 64'hC000_0000_0000_0001, T_SPEC, 0, EMAX, 64'h8000_0000_0000_0007, T_SPEC, 0, 0, 2'b00, 1);
    expect_dec("R10 two nan a larger", O_FORM, 0, 0, T_SPEC, 1, 0);
    check("R10 pick a", out_sig, 64'hC000_0000_0000_0001);
    send(0, EMAX, 64'h8000_0000_0000_0005, T_SPEC, 1, EMAX, 64'hC000_0000_0000_0002, T_SPEC, 0, 0, 2'b00, 1);
    expect_dec("R10 two nan b larger", O_FORM, 0, 1, T_SPEC, 1, 0);
    check("R10 pick b", out_sig, 64'hC000_0000_0000_0002);
  endtask

  task automatic t_empty;
    send(0, 15'h4000, S_INF, T_EMPTY, 0, 15'h4000, S_INF, T_VAL, 0, 0, 2'b00, 1);
    expect_dec("R1 empty operand", O_EXC, 0, 0, T_VAL, 1, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    a_sign = 0; a_exp = 15'h4000; a_sig = S_INF; a_tag = T_VAL;
    b_sign = 0; b_exp = 15'h4000; b_sig = S_INF; b_tag = T_VAL;
    op_sub = 0; op_rev = 0; rnd_mode = 2'b00; den_mask = 1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R11 first out", 64'(out_op), 64'(O_ADD));
    check("R11 stalled ready", 64'(in_ready), 64'd0);
    a_tag = T_EMPTY;
    @(negedge clk);
    check("R11 held valid", 64'(out_valid), 64'd1);
    check("R11 held op", 64'(out_op), 64'(O_ADD));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second out", 64'(out_op), 64'(O_EXC));
    @(negedge clk);
    check("R11 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_wb;
    @(negedge clk);
    rsp_valid = 1; rsp_err = 1; rsp_sign = 1; rsp_tag = T_SPEC; dst_old_sign = 0;
    @(negedge clk);
    rsp_valid = 1; rsp_err = 0; rsp_sign = 1; rsp_tag = T_ZERO; dst_old_sign = 0;
    check("R12 err valid", 64'(wb_valid), 64'd1);
    check("R12 err no tag", 64'(wb_tag_we), 64'd0);
    check("R12 err old sign", 64'(wb_sign), 64'd0);
    @(negedge clk);
    rsp_valid = 0;
    check("R12 ok tag we", 64'(wb_tag_we), 64'd1);
    check("R12 ok sign", 64'(wb_sign), 64'd1);
    check("R12 ok tag", 64'(wb_tag), 64'(T_ZERO));
    @(negedge clk);
    check("R12 idle", 64'(wb_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_effsign();
    t_order();
    t_eqzero();
    t_zeros();
    t_onezero();
    t_inf();
    t_denorm();
    t_nan();
    t_empty();
    t_backpressure();
    t_wb();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule